// File: doc/BRIEF.md
# Flag-Conditioned Relative Branch Unit

This block holds the program counter of a small 8-bit controller core and updates it for one class of instruction: the short relative branch that jumps when a status flag is clear. Every instruction cycle is split into four clock phases. An instruction word and the zero and overflow flags are captured once per cycle. The word is decoded, its signed byte offset is read, and the taken/not-taken decision and the target address are formed. The program counter is then written in the last phase.

The program counter is a byte address that always steps in words. A branch that is not taken, and any word that is not a branch, advances it by two in one instruction cycle. A taken branch loads the target and then inserts a dead instruction cycle. During that cycle the prefetched word is discarded, `flush` is high, and no new word is accepted. A fetch stage around this block uses `accept` to know when to present the next word.

Top module: `cbr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the unit clears `pc` to 0, sets `phase` to 0 (first phase), and drives `flush` low and `accept` high.
- R2: `phase` steps 0,1,2,3,0,… on every clock. `instr_word`, `flag_zero` and `flag_ovf` are captured at the clock edge that ends phase 0 of a cycle in which `accept` is high.
- R3: An upper byte of 8'hE1 selects the not-zero branch, which tests `flag_zero`. An upper byte of 8'hE5 selects the not-overflow branch, which tests `flag_ovf`. Either branch is taken exactly when its tested flag is 0.
- R4: A taken branch loads `pc` with HERE + 2 + 2·n modulo 2^PC_W. HERE is the address of the branch and n is the low byte of the word read as two's complement (−128..127).
- R5: A branch that is not taken, and any word whose upper byte is neither 8'hE1 nor 8'hE5, sets `pc` to HERE + 2 and takes one instruction cycle (four clocks).
- R6: A taken branch is followed by exactly one dead instruction cycle. In it `flush` is high and `accept` is low for all four phases, and `pc` holds the target. The next word is then accepted.
- R7: Bit 0 of `pc` is always 0.
- R8: `pc` changes only at the clock edge that ends phase 3.
- R9: The flag that a branch does not test has no effect on its outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per phase |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 16 | Instruction word presented while `accept` is high |
| flag_zero | input | 1 | Zero status flag |
| flag_ovf | input | 1 | Overflow status flag |
| pc | output | PC_W | Byte-addressed program counter |
| phase | output | 2 | Current phase within the instruction cycle |
| accept | output | 1 | Word and flags are captured at the next edge |
| flush | output | 1 | Dead cycle after a taken branch; prefetched word discarded |

## Verification
Assertions check the invariants on every cycle: the phase step, the even program counter, that the counter moves only at the end of phase 3, that it holds through a dead cycle, that a dead cycle lasts one instruction cycle, and the plus-two step for a non-branch word. Only the bench scenarios can show the branch arithmetic end to end. The bench sweeps every offset of both branches under all four flag combinations, which covers the sign extension, the wrap past either end of the address space and the flag selection. It also runs every upper byte as a plain word, so the opcodes next to the two branch codes are shown to fall through.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    typedef enum logic [1:0] {
        PH_DECODE  = 2'd0,
        PH_LITERAL = 2'd1,
        PH_PROCESS = 2'd2,
        PH_WRITE   = 2'd3
    } phase_e;

    localparam logic [7:0] OPC_SKIPZ_N  = 8'hE1;
    localparam logic [7:0] OPC_SKIPOV_N = 8'hE5;

    typedef struct packed {
        logic       is_branch;
        logic       taken;
        logic [7:0] offset;
    } br_dec_t;

    function automatic phase_e phase_after(input phase_e p);
        phase_e r;
        unique case (p)
            PH_DECODE:  r = PH_LITERAL;
            PH_LITERAL: r = PH_PROCESS;
            PH_PROCESS: r = PH_WRITE;
            default:    r = PH_DECODE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cbr_phase_seq.sv
module cbr_phase_seq
    import cbr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase
);

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_DECODE;
        else     phase <= phase_after(phase);
    end

    p_phase_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> phase == phase_after($past(phase)));

endmodule

// File: rtl/cbr_decode.sv
module cbr_decode
    import cbr_pkg::*;
(
    input  logic [15:0] word,
    input  logic        z,
    input  logic        v,
    output br_dec_t     dec
);

    logic hit_z;
    logic hit_v;

    always_comb begin
        hit_z      = (word[15:8] == OPC_SKIPZ_N);
        hit_v      = (word[15:8] == OPC_SKIPOV_N);
        dec.offset = word[7:0];
        dec.is_branch = hit_z | hit_v;
        dec.taken  = (hit_z & ~z) | (hit_v & ~v);
    end

endmodule

// File: rtl/cbr_target.sv
module cbr_target #(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] here,
    input  logic [7:0]      off,
    output logic [PC_W-1:0] next_seq,
    output logic [PC_W-1:0] jump
);

    localparam int EXT_W = PC_W - 9;
    localparam logic [PC_W-1:0] STEP = PC_W'(2);

    logic [PC_W-1:0] disp;

    always_comb begin
        disp     = {{EXT_W{off[7]}}, off, 1'b0};
        next_seq = here + STEP;
        jump     = next_seq + disp;
    end

endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
    import cbr_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [15:0]     instr_word,
    input  logic            flag_zero,
    input  logic            flag_ovf,
    output logic [PC_W-1:0] pc,
    output logic [1:0]      phase,
    output logic            accept,
    output logic            flush
);

    phase_e          ph;
    logic [15:0]     ir_q;
    logic            z_q;
    logic            v_q;
    logic [7:0]      off_q;
    logic            taken_q;
    logic [PC_W-1:0] tgt_q;
    logic [PC_W-1:0] seq_q;
    logic            dead_q;
    br_dec_t         dec;
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] jump_pc;

    cbr_phase_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .phase (ph)
    );

    cbr_decode u_dec (
        .word (ir_q),
        .z    (z_q),
        .v    (v_q),
        .dec  (dec)
    );

    cbr_target #(.PC_W(PC_W)) u_tgt (
        .here     (pc),
        .off      (off_q),
        .next_seq (seq_pc),
        .jump     (jump_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q    <= '0;
            z_q     <= 1'b0;
            v_q     <= 1'b0;
            off_q   <= '0;
            taken_q <= 1'b0;
            tgt_q   <= '0;
            seq_q   <= '0;
            dead_q  <= 1'b0;
            pc      <= '0;
        end else if (!dead_q) begin
            unique case (ph)
                PH_DECODE: begin
                    ir_q <= instr_word;
                    z_q  <= flag_zero;
                    v_q  <= flag_ovf;
                end
                PH_LITERAL: off_q <= dec.offset;
                PH_PROCESS: begin
                    taken_q <= dec.taken;
                    tgt_q   <= jump_pc;
                    seq_q   <= seq_pc;
                end
                default: begin
                    pc     <= taken_q ? tgt_q : seq_q;
                    dead_q <= taken_q;
                end
            endcase
        end else if (ph == PH_WRITE) begin
            dead_q <= 1'b0;
        end
    end

    always_comb begin
        phase  = ph;
        flush  = dead_q;
        accept = (ph == PH_DECODE) && !dead_q;
    end

    p_pc_even_r7: assert property (@(posedge clk) disable iff (rst)
        pc[0] == 1'b0);

    p_pc_only_q4_r8: assert property (@(posedge clk) disable iff (rst)
        ph != PH_WRITE |=> $stable(pc));

    p_dead_hold_r6: assert property (@(posedge clk) disable iff (rst)
        flush |=> $stable(pc));

    p_dead_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        (flush && ph == PH_WRITE) |=> !flush);

    p_dead_start_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(flush) |-> ph == PH_DECODE);

    p_plain_step_r5: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_WRITE && !dead_q && !dec.is_branch)
            |=> pc == $past(pc) + PC_W'(2));

endmodule

// File: tb/cbr_unit_bench.sv
module cbr_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 16;
    localparam int WATCHDOG = 150000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [15:0]     instr_word = '0;
    logic            flag_zero = 1'b0;
    logic            flag_ovf = 1'b0;
    logic [PC_W-1:0] pc;
    logic [1:0]      phase;
    logic            accept;
    logic            flush;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cbr_unit #(.PC_W(PC_W)) u_cbr_unit (
        .clk        (clk),
        .rst        (rst),
        .instr_word (instr_word),
        .flag_zero  (flag_zero),
        .flag_ovf   (flag_ovf),
        .pc         (pc),
        .phase      (phase),
        .accept     (accept),
        .flush      (flush)
    );

    task automatic check(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Runs one word from phase 0 through its last cycle; called right after a negedge with accept high.
    task automatic run_word(input logic [15:0] w, input logic z, input logic v);
        logic [PC_W-1:0] here;
        logic [PC_W-1:0] exp_pc;
        bit              tk;
        int              n;
        here = pc;
        check("R2 accept", int'(accept), 1);
        check("R2 phase0", int'(phase), 0);
        instr_word = w;
        flag_zero  = z;
        flag_ovf   = v;
        n  = (w[7] ? int'(w[7:0]) - 256 : int'(w[7:0]));
        tk = (w[15:8] == 8'hE1 && !z) || (w[15:8] == 8'hE5 && !v);
        exp_pc = tk ? PC_W'(int'(here) + 2 + 2 * n) : PC_W'(int'(here) + 2);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            instr_word = ~w;
            flag_zero  = ~z;
            flag_ovf   = ~v;
            check("R8 pc held", int'(pc), int'(here));
        end
        @(negedge clk);
        if (tk) begin
            check("R4 R9 target", int'(pc), int'(exp_pc));
            check("R6 flush", int'(flush), 1);
            check("R6 accept low", int'(accept), 0);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (flush !== 1'b1 || accept !== 1'b0 || pc !== exp_pc)
                    check("R6 dead cycle", int'(pc), int'(exp_pc) + 1);
            end
            @(negedge clk);
            check("R6 dead ends", int'(flush), 0);
            check("R6 pc kept", int'(pc), int'(exp_pc));
        end else begin
            check("R5 R3 R9 step", int'(pc), int'(exp_pc));
            check("R5 no flush", int'(flush), 0);
        end
        check("R7 even", int'(pc[0]), 0);
    endtask

    initial begin : watchdog
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 pc", int'(pc), 0);
        check("R1 phase", int'(phase), 0);
        check("R1 flush", int'(flush), 0);
        check("R1 accept", int'(accept), 1);

        // R4 wrap below zero: from 0 with n = -128
        run_word(16'hE180, 1'b0, 1'b1);
        check("R4 wrap low", int'(pc), 16'hFF02);
        // R4 wrap above top: 0xFF02 + 2 + 254
        run_word(16'hE57F, 1'b1, 1'b0);
        check("R4 wrap high", int'(pc), 16'h0002);

        // R3 R4 R9 sweep: both opcodes, all offsets, all flag pairs
        for (int op = 0; op < 2; op++)
            for (int f = 0; f < 4; f++)
                for (int n = 0; n < 256; n++)
                    run_word({(op == 0) ? 8'hE1 : 8'hE5, 8'(n)}, f[0], f[1]);

        // R5 every upper byte as a plain word, flags clear
        for (int u = 0; u < 256; u++)
            run_word({8'(u), 8'(u * 7)}, 1'b0, 1'b0);

        // R1 reset mid-cycle returns to the reset state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 pc again", int'(pc), 0);
        check("R1 phase again", int'(phase), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule